// File: doc/BRIEF.md
# Serial 1-D Inverse DCT Stage

This block computes an 8-point one-dimensional inverse DCT over a single vector of eight frequency-domain values. It loads the eight values into local registers. A single multiply-accumulate unit then forms each output as the weighted sum of all eight inputs. The weights come from a cosine table computed at elaboration. Each sum is rounded and saturated to a parameterised output width before it leaves the block.

A row–column 2-D transform uses two instances, one for each pass. The first pass takes 11-bit signed coefficients and keeps 15-bit intermediates with three fraction bits. The second pass takes those intermediates, with its own input width and rounding shift. Transpose storage, block framing and pixel clamping sit outside this block.

Top module: `idct_1d_mac`

## Requirements
- R1: Table entry (x,u) equals round(2^14 · k(u)/2 · cos((2x+1)·u·π/16)), where k(0)=1/√2 and k(u)=1 for u>0, held as a 16-bit signed value.
- R2: Result x is the sum over u=0..7 of S(u) times entry (x,u), accumulated without loss in IN_W+19 bits. 2^(RSH-1) is then added, the sum is shifted right arithmetically by RSH (default 11), and the value is saturated to OUT_W signed bits (default 15).
- R3: While idle, a cycle with `valid_i` and `sov_i` both high loads S(0) from `sample_i`. The next seven cycles with `valid_i` high load S(1)..S(7) in order, and `sov_i` is not examined during this phase.
- R4: Results appear in order x=0..7 on `res_o`, with `res_idx_o`=x and a one-cycle `res_valid_o` pulse for each. The pulses are exactly 8 cycles apart, and the first pulse comes 8 clock edges after the edge that accepts S(7).
- R5: `busy_o` rises on the edge after a start is accepted. It stays high through the 64 computation cycles and falls on the same edge as the x=7 result.
- R6: While the block is busy computing, `valid_i` and `sov_i` have no effect: results are unchanged, and no new vector starts once the current one completes.
- R7: Extreme inputs (all +1023 or all −1024 at default widths) saturate to +16383 or −16384 with no accumulator wrap.
- R8: After reset `busy_o`, `res_valid_o`, `res_idx_o` and `res_o` are all zero. A reset during a computation returns the block to idle, ready for a new vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample on `sample_i` is present |
| sov_i | input | 1 | Marks S(0), the first sample of a vector |
| sample_i | input | IN_W | Signed input sample |
| busy_o | output | 1 | A vector is being loaded or computed |
| res_valid_o | output | 1 | One-cycle pulse per result |
| res_idx_o | output | 3 | Index x of the current result |
| res_o | output | OUT_W | Rounded, saturated signed result |

## Verification
The stimulus set includes a DC-only vector, which gives a flat output and isolates the k(0) weight. A single first-harmonic vector exposes sign and index errors in the table fold-over. An alternating-sign vector and a ramp mix all table entries, and they catch wrong pairing of x with u and mistakes in the accumulate-clear timing. Two saturating vectors separate correct clipping from accumulator wrap. A run with start pulses injected mid-computation shows that such pulses are ignored. A reset issued mid-vector shows that the block recovers cleanly.

// File: rtl/idct_pkg.sv
package idct_pkg;
  localparam int COEF_W = 16;
  localparam int COEF_FRAC = 14;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC} idct_state_e;

  // round(2^13 * cos(k*pi/16)), k = 0..8
  function automatic logic signed [COEF_W-1:0] cos_half(input int k);
    case (k)
      0: return 16'sd8192;
      1: return 16'sd8035;
      2: return 16'sd7568;
      3: return 16'sd6811;
      4: return 16'sd5793;
      5: return 16'sd4551;
      6: return 16'sd3135;
      7: return 16'sd1598;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [COEF_W-1:0] idct_coef(input int x, input int u);
    int m;
    if (u == 0) return cos_half(4);  // 1/(2*sqrt2) == cos(pi/4)/2
    m = ((2 * x + 1) * u) % 32;
    if (m <= 8)       return cos_half(m);
    else if (m <= 16) return -cos_half(16 - m);
    else if (m <= 24) return -cos_half(m - 16);
    else              return cos_half(32 - m);
  endfunction
endpackage

// File: rtl/idct_coef_rom.sv
module idct_coef_rom
  import idct_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [IW-1:0]             x_i,
  input  logic [IW-1:0]             u_i,
  output logic signed [COEF_W-1:0]  coef_o
);
  logic signed [COEF_W-1:0] tbl [N*N];

  for (genvar gx = 0; gx < N; gx++) begin : g_row
    for (genvar gu = 0; gu < N; gu++) begin : g_col
      assign tbl[gx*N+gu] = idct_coef(gx, gu);
    end
  end

  assign coef_o = tbl[{x_i, u_i}];
endmodule

// File: rtl/idct_mac.sv
module idct_mac #(
  parameter int A_W   = 11,
  parameter int B_W   = 16,
  parameter int ACC_W = 30,
  localparam int P_W  = A_W + B_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     clr_i,
  input  logic signed [A_W-1:0]    a_i,
  input  logic signed [B_W-1:0]    b_i,
  output logic signed [ACC_W-1:0]  sum_o
);
  logic signed [P_W-1:0]   prod;
  logic signed [ACC_W-1:0] acc_q;

  assign prod  = a_i * b_i;
  assign sum_o = (clr_i ? '0 : acc_q) + ACC_W'(prod);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum_o;
  end
endmodule

// File: rtl/idct_round_sat.sv
module idct_round_sat #(
  parameter int ACC_W = 30,
  parameter int OUT_W = 15,
  parameter int RSH   = 11
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic signed [OUT_W-1:0] res_o
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (RSH - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (OUT_W - 1));

  logic signed [ACC_W-1:0] biased, shifted;

  assign biased  = acc_i + HALF;
  assign shifted = biased >>> RSH;

  always_comb begin
    if (shifted > MAXV)      res_o = OUT_W'(MAXV);
    else if (shifted < MINV) res_o = OUT_W'(MINV);
    else                     res_o = OUT_W'(shifted);
  end
endmodule

// File: rtl/idct_1d_mac.sv
module idct_1d_mac
  import idct_pkg::*;
#(
  parameter int IN_W  = 11,
  parameter int OUT_W = 15,
  parameter int RSH   = 11,
  parameter int N     = 8,
  localparam int IW    = $clog2(N),
  localparam int CW    = 2 * IW,
  localparam int ACC_W = IN_W + COEF_W + IW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sov_i,
  input  logic signed [IN_W-1:0]  sample_i,
  output logic                    busy_o,
  output logic                    res_valid_o,
  output logic [IW-1:0]           res_idx_o,
  output logic signed [OUT_W-1:0] res_o
);
  idct_state_e              state_q;
  logic [IW-1:0]            ld_q;
  logic [CW-1:0]            cnt_q;
  logic signed [IN_W-1:0]   smp_q [N];
  logic [IW-1:0]            x_idx, u_idx;
  logic signed [COEF_W-1:0] coef;
  logic signed [ACC_W-1:0]  sum;
  logic signed [OUT_W-1:0]  rnd;
  logic                     calc, last_u;

  assign x_idx  = cnt_q[CW-1:IW];
  assign u_idx  = cnt_q[IW-1:0];
  assign calc   = (state_q == ST_CALC);
  assign last_u = (u_idx == IW'(N - 1));
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ld_q    <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < N; i++) smp_q[i] <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (valid_i && sov_i) begin
          smp_q[0] <= sample_i;
          ld_q     <= IW'(1);
          state_q  <= ST_LOAD;
        end
        ST_LOAD: if (valid_i) begin
          smp_q[ld_q] <= sample_i;
          ld_q        <= ld_q + IW'(1);
          if (ld_q == IW'(N - 1)) begin
            state_q <= ST_CALC;
            cnt_q   <= '0;
          end
        end
        ST_CALC: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == CW'(N * N - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  idct_coef_rom #(.N(N)) i_rom (
    .x_i    (x_idx),
    .u_i    (u_idx),
    .coef_o (coef)
  );

  idct_mac #(.A_W(IN_W), .B_W(COEF_W), .ACC_W(ACC_W)) i_mac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (calc),
    .clr_i  (u_idx == '0),
    .a_i    (smp_q[u_idx]),
    .b_i    (coef),
    .sum_o  (sum)
  );

  idct_round_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W), .RSH(RSH)) i_rnd (
    .acc_i (sum),
    .res_o (rnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_idx_o   <= '0;
      res_o       <= '0;
    end else begin
      res_valid_o <= calc && last_u;
      if (calc && last_u) begin
        res_idx_o <= x_idx;
        res_o     <= rnd;
      end
    end
  end
endmodule

// File: rtl/idct_1d_mac_chk.sv
module idct_1d_mac_chk #(
  parameter int IN_W  = 11,
  parameter int OUT_W = 15
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    sov_i,
  input logic signed [IN_W-1:0]  sample_i,
  input logic                    busy_o,
  input logic                    res_valid_o,
  input logic [2:0]              res_idx_o,
  input logic signed [OUT_W-1:0] res_o
);
  // R4
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  // R4
  idx_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_idx_o != 3'd0) |-> ($past(res_valid_o, 8) && $past(res_idx_o, 8) == res_idx_o - 3'd1));

  // R5
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(valid_i && sov_i));

  // R5
  res_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(busy_o));

  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (res_valid_o && res_idx_o == 3'd7));
endmodule

bind idct_1d_mac idct_1d_mac_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) i_idct_1d_mac_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .sov_i       (sov_i),
  .sample_i    (sample_i),
  .busy_o      (busy_o),
  .res_valid_o (res_valid_o),
  .res_idx_o   (res_idx_o),
  .res_o       (res_o)
);

// File: tb/test_idct_1d_mac.sv
module test_idct_1d_mac;
  localparam int IN_W  = 11;
  localparam int OUT_W = 15;
  localparam int RSH   = 11;
  localparam real PI   = 3.14159265358979323846;
  localparam int NV    = 6;
  localparam int VEC [NV][8] = '{
    '{ 100,    0,    0,    0,    0,    0,    0,    0},
    '{   0,  200,    0,    0,    0,    0,    0,    0},
    '{ 300, -300,  300, -300,  300, -300,  300, -300},
    '{ -70,  -45,  -20,    5,   30,   55,   80,  105},
    '{1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023},
    '{-1024,-1024,-1024,-1024,-1024,-1024,-1024,-1024}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic sov_i = 1'b0;
  logic signed [IN_W-1:0] sample_i = '0;
  logic busy_o, res_valid_o;
  logic [2:0] res_idx_o;
  logic signed [OUT_W-1:0] res_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  idct_1d_mac #(.IN_W(IN_W), .OUT_W(OUT_W), .RSH(RSH)) i_idct_1d_mac (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sov_i(sov_i),
    .sample_i(sample_i), .busy_o(busy_o), .res_valid_o(res_valid_o),
    .res_idx_o(res_idx_o), .res_o(res_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R1/R2 reference: real-valued table, quantised, exact sum, round half up, saturate
  function automatic int model(input int s[8], input int x);
    longint acc = 0;
    longint r;
    for (int u = 0; u < 8; u++) begin
      real k = (u == 0) ? 1.0 / $sqrt(2.0) : 1.0;
      real c = k / 2.0 * $cos((2.0 * x + 1.0) * u * PI / 16.0);
      longint q = longint'(c * 16384.0);
      acc += longint'(s[u]) * q;
    end
    r = (acc + (longint'(1) <<< (RSH - 1))) >>> RSH;
    if (r > (1 <<< (OUT_W - 1)) - 1) r = (1 <<< (OUT_W - 1)) - 1;
    if (r < -(1 <<< (OUT_W - 1)))    r = -(1 <<< (OUT_W - 1));
    return int'(r);
  endfunction

  task automatic send(input int s[8]);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      valid_i  = 1'b1;
      sov_i    = (k == 0);
      sample_i = IN_W'(s[k]);
    end
    @(negedge clk);
    valid_i = 1'b0; sov_i = 1'b0; sample_i = '0;
  endtask

  // Cycle c counts negedges after the last sample was driven (c=1 is the one send() ends on)
  task automatic run_vec(input int s[8], input bit junk, input string tag);
    int got = 0;
    send(s);
    for (int c = 1; c <= 90; c++) begin
      if (c > 1) @(negedge clk);
      if (res_valid_o) begin
        check({tag, " R4 timing"}, c, 9 + 8 * got);
        check({tag, " R4 index"}, int'(res_idx_o), got);
        check({tag, " R2 value"}, int'(res_o), model(s, got));
        got++;
      end
      if (c == 64) check({tag, " R5 busy high"}, int'(busy_o), 1);
      if (c == 65) check({tag, " R5 busy low"}, int'(busy_o), 0);
      if (junk) begin
        valid_i  = (c >= 20 && c < 28);
        sov_i    = (c >= 20 && c < 28);
        sample_i = (c >= 20 && c < 28) ? IN_W'(-500) : '0;
      end
    end
    check({tag, " R4 count"}, got, 8);
    if (junk) check({tag, " R6 no restart"}, int'(busy_o), 0);
  endtask

  initial begin
    #500us;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int v[8];
    #1;
    // R8 reset state
    check("R8 busy", int'(busy_o), 0);
    check("R8 valid", int'(res_valid_o), 0);
    check("R8 res", int'(res_o), 0);
    check("R8 idx", int'(res_idx_o), 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3: valid without sov while idle must not start
    @(negedge clk); valid_i = 1'b1; sample_i = IN_W'(77);
    @(negedge clk); valid_i = 1'b0; sample_i = '0;
    check("R3 no start w/o sov", int'(busy_o), 0);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 8; k++) v[k] = VEC[i][k];
      run_vec(v, 1'b0, (i >= 4) ? "R7 sat" : "R1 table");
    end

    // R6: start pulses during computation are ignored
    for (int k = 0; k < 8; k++) v[k] = VEC[3][k];
    run_vec(v, 1'b1, "R6 ignore");

    // R8: reset mid-computation, then a clean vector
    for (int k = 0; k < 8; k++) v[k] = VEC[1][k];
    send(v);
    repeat (20) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R8 mid reset busy", int'(busy_o), 0);
    check("R8 mid reset valid", int'(res_valid_o), 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) v[k] = VEC[2][k];
    run_vec(v, 1'b0, "R8 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule